// File: doc/BRIEF.md
# Phase Quadrant Code Encoder

This block takes a stream of complex filter responses and reduces each one to a two-bit phase code and a mask bit. Every input beat carries a signed real part, a signed imaginary part and a noise flag from an earlier stage. The two code bits give the quadrant of the response's phase. Each bit comes from the sign of one of the two parts.

The mask bit marks samples that should not take part in later comparison. It is set for either of two reasons. The first is that the response is too weak: its magnitude, approximated as the sum of absolute values, falls below a threshold that software can write. The second is that the incoming noise flag is already set. Both sides of the block use valid/ready handshaking. One register stage sits between input and output, and a stalled consumer holds back the producer.

Top module: `qc_encoder`

## Requirements
- R1: After reset, out_valid is 0 and the threshold is 0, so a sample with a clear incoming noise flag is not masked.
- R2: out_code[1] (the real bit) is 1 when the real part is zero or positive and 0 when it is negative; the inputs are 16-bit two's complement.
- R3: out_code[0] (the imaginary bit) is 1 when the imaginary part is zero or positive and 0 when it is negative.
- R4: A part equal to zero gives a code bit of 1, so re=0 and im=0 yield code 2'b11.
- R5: out_mask is 1 when |re|+|im| is strictly less than the 17-bit unsigned threshold; a magnitude equal to the threshold is not masked.
- R6: out_mask is 1 whenever in_noise was 1 on the accepted beat, whatever the magnitude.
- R7: A beat is accepted on a rising edge with in_valid and in_ready both high; its result appears with out_valid high right after that same edge, and out_valid falls after a drain edge on which no new beat is accepted.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_code and out_mask hold their values.
- R9: A threshold write (thr_we high at an edge) applies to beats accepted at later edges; a beat accepted on the same edge uses the old threshold.
- R10: The magnitude of the most negative inputs is exact: re=im=-32768 gives magnitude 65536. That beat is masked for a threshold of 65537 and not masked for a threshold of 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_we | input | 1 | Threshold write enable |
| thr_wdata | input | 17 | New threshold value |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_re | input | 16 | Real part, signed |
| in_im | input | 16 | Imaginary part, signed |
| in_noise | input | 1 | Upstream noise flag |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_code | output | 2 | {real_bit, imag_bit} |
| out_mask | output | 1 | Noise mask bit |

## Verification
Three faults show at the output on the beat that follows acceptance, one cycle after the edge: a corrupted sign path flips a code bit, a wrong comparison flips out_mask, and a lost OR term flips out_mask. The boundary beats catch an off-by-one in the comparison: magnitude equal to the threshold, and the -32768 pair. A broken ready path shows up in two ways. A beat may be overwritten during a stall, in which case the held output changes. A beat may be dropped, in which case the next drained value is wrong. A stale or early threshold register shows up in the mask of the beat accepted on the write edge.

// File: rtl/qc_pkg.sv
package qc_pkg;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned MAG_W  = DATA_W + 1;

    typedef struct packed {
        logic [1:0] code;
        logic       mask;
    } qc_result_t;

    function automatic logic [MAG_W-1:0] abs_ext(input logic [DATA_W-1:0] v);
        logic [MAG_W-1:0] ext;
        ext = {v[DATA_W-1], v};
        return v[DATA_W-1] ? (~ext + 1'b1) : ext;
    endfunction
endpackage

// File: rtl/qc_thresh_reg.sv
module qc_thresh_reg #(
    parameter int unsigned W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] thr
);
    always_ff @(posedge clk) begin
        if (rst)     thr <= '0;
        else if (we) thr <= wdata;
    end
endmodule

// File: rtl/qc_quant.sv
module qc_quant
    import qc_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0]   re,
    input  logic [W-1:0]   im,
    input  logic           noise,
    input  logic [W:0]     thr,
    output qc_result_t     res
);
    localparam int unsigned LANES = 2;
    logic [W-1:0] lane_in  [LANES];
    logic [W:0]   lane_abs [LANES];
    logic         lane_bit [LANES];
    logic [W:0]   mag;

    assign lane_in[0] = re;
    assign lane_in[1] = im;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [W:0] ext;
        assign ext         = {lane_in[g][W-1], lane_in[g]};
        assign lane_abs[g] = lane_in[g][W-1] ? (~ext + 1'b1) : ext;
        assign lane_bit[g] = ~lane_in[g][W-1];
    end

    assign mag = lane_abs[0] + lane_abs[1];

    always_comb begin
        res.code = {lane_bit[0], lane_bit[1]};
        res.mask = noise | (mag < thr);
    end
endmodule

// File: rtl/qc_out_stage.sv
module qc_out_stage
    import qc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       drain,
    input  qc_result_t d,
    output qc_result_t q,
    output logic       valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            q     <= '0;
        end else if (load) begin
            valid <= 1'b1;
            q     <= d;
        end else if (drain) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/qc_encoder.sv
module qc_encoder
    import qc_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         thr_we,
    input  logic [W:0]   thr_wdata,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_re,
    input  logic [W-1:0] in_im,
    input  logic         in_noise,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [1:0]   out_code,
    output logic         out_mask
);
    localparam int unsigned TW = W + 1;

    logic [TW-1:0] thr;
    qc_result_t    res_d, res_q;
    logic          accept;

    qc_thresh_reg #(.W(TW)) u_thr (
        .clk(clk), .rst(rst), .we(thr_we), .wdata(thr_wdata), .thr(thr)
    );

    qc_quant #(.W(W)) u_quant (
        .re(in_re), .im(in_im), .noise(in_noise), .thr(thr), .res(res_d)
    );

    assign in_ready = ~out_valid | out_ready;
    assign accept   = in_valid & in_ready;

    qc_out_stage u_out (
        .clk(clk), .rst(rst), .load(accept), .drain(out_ready),
        .d(res_d), .q(res_q), .valid(out_valid)
    );

    assign out_code = res_q.code;
    assign out_mask = res_q.mask;
endmodule

// File: rtl/qc_encoder_chk.sv
module qc_encoder_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic [W-1:0] in_re,
    input logic [W-1:0] in_im,
    input logic         in_noise,
    input logic         out_valid,
    input logic         out_ready,
    input logic [1:0]   out_code,
    input logic         out_mask
);
    assert_accept_valid_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    assert_stall_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_mask)));

    assert_real_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_code[1] == !$past(in_re[W-1])));

    assert_imag_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_code[0] == !$past(in_im[W-1])));

    assert_noise_masks_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_noise) |=> out_mask);
endmodule

bind qc_encoder qc_encoder_chk #(.W(W)) chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .in_noise(in_noise), .out_valid(out_valid),
    .out_ready(out_ready), .out_code(out_code), .out_mask(out_mask)
);

// File: tb/qc_encoder_test.sv
module qc_encoder_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        thr_we;
    logic [16:0] thr_wdata;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_re, in_im;
    logic        in_noise;
    logic        out_valid;
    logic        out_ready;
    logic [1:0]  out_code;
    logic        out_mask;

    int checks = 0;
    int failures = 0;
    logic [16:0] cur_thr = '0;
    bit done = 0;

    always #5 clk = ~clk;

    qc_encoder uut (
        .clk(clk), .rst(rst), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
        .in_noise(in_noise), .out_valid(out_valid), .out_ready(out_ready),
        .out_code(out_code), .out_mask(out_mask)
    );

    function automatic logic [16:0] mag_of(input logic [15:0] a, input logic [15:0] b);
        int ia, ib;
        ia = $signed(a); ib = $signed(b);
        if (ia < 0) ia = -ia;
        if (ib < 0) ib = -ib;
        return 17'(ia + ib);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_thr(input logic [16:0] v);
        @(negedge clk);
        thr_we = 1'b1; thr_wdata = v;
        @(negedge clk);
        thr_we = 1'b0;
        cur_thr = v;
    endtask

    // Sends one beat with out_ready high and checks code and mask.
    task automatic send_check(input string req, input logic [15:0] re,
                              input logic [15:0] im, input logic nz);
        logic [2:0] exp;
        @(negedge clk);
        out_ready = 1'b1;
        in_valid = 1'b1; in_re = re; in_im = im; in_noise = nz;
        exp = {~re[15], ~im[15], nz | (mag_of(re, im) < cur_thr)};
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, int'(out_valid), 1);
        check({req, " code/mask"}, int'({out_code, out_mask}), int'(exp));
    endtask

    task automatic t_reset;
        rst = 1'b1; thr_we = 0; thr_wdata = 0; in_valid = 0;
        in_re = 0; in_im = 0; in_noise = 0; out_ready = 1;
        repeat (3) @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 in_ready after reset", int'(in_ready), 1);
        send_check("R1 zero threshold", 16'd1, 16'd0, 1'b0);
        check("R1 no mask", int'(out_mask), 0);
    endtask

    task automatic t_quadrants;
        send_check("R2 R3 q1", 16'd100, 16'd200, 0);
        check("R2 R3 q1 code", int'(out_code), 3);
        send_check("R2 R3 q2", -16'sd100, 16'd5, 0);
        check("R2 q2 code", int'(out_code), 1);
        send_check("R2 R3 q3", -16'sd7, -16'sd9, 0);
        check("R3 q3 code", int'(out_code), 0);
        send_check("R3 q4", 16'd7, -16'sd1, 0);
        check("R3 q4 code", int'(out_code), 2);
        send_check("R4 zeros", 16'd0, 16'd0, 0);
        check("R4 zero code", int'(out_code), 3);
    endtask

    task automatic t_threshold;
        write_thr(17'd300);
        send_check("R5 below", 16'd100, -16'sd199, 0);
        check("R5 below mask", int'(out_mask), 1);
        send_check("R5 equal", -16'sd150, 16'd150, 0);
        check("R5 equal mask", int'(out_mask), 0);
        send_check("R5 above", 16'd301, 16'd0, 0);
        send_check("R6 noise strong", 16'd30000, 16'd30000, 1);
        check("R6 noise mask", int'(out_mask), 1);
    endtask

    task automatic t_same_edge_write;
        // threshold 300 in force; write 10 on the same edge as a beat of magnitude 50
        @(negedge clk);
        out_ready = 1; thr_we = 1; thr_wdata = 17'd10;
        in_valid = 1; in_re = 16'd25; in_im = 16'd25; in_noise = 0;
        @(negedge clk);
        thr_we = 0; in_valid = 0; cur_thr = 17'd10;
        check("R9 same-edge uses old", int'(out_mask), 1);
        send_check("R9 later uses new", 16'd25, 16'd25, 0);
        check("R9 new mask", int'(out_mask), 0);
    endtask

    task automatic t_extreme;
        write_thr(17'd65537);
        send_check("R10 min masked", 16'h8000, 16'h8000, 0);
        check("R10 min mask", int'(out_mask), 1);
        write_thr(17'd65536);
        send_check("R10 min equal", 16'h8000, 16'h8000, 0);
        check("R10 equal no mask", int'(out_mask), 0);
        check("R10 code", int'(out_code), 0);
    endtask

    task automatic t_stall;
        write_thr(17'd0);
        @(negedge clk);
        out_ready = 0; in_valid = 1; in_re = -16'sd3; in_im = 16'd4; in_noise = 1;
        @(negedge clk);
        in_re = 16'd8; in_im = -16'sd8; in_noise = 0;
        check("R8 in_ready low", int'(in_ready), 0);
        repeat (3) @(negedge clk);
        check("R8 held valid", int'(out_valid), 1);
        check("R8 held data", int'({out_code, out_mask}), 3);
        out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        check("R7 next beat", int'({out_code, out_mask}), 4);
        @(negedge clk);
        check("R7 drained", int'(out_valid), 0);
    endtask

    initial begin
        t_reset();
        t_quadrants();
        t_threshold();
        t_same_edge_write();
        t_extreme();
        t_stall();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule